// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block lets on-chip logic read and program a small serial EEPROM of 128 bytes over the three-wire Microwire bus, using a chip-select line, a serial clock and a data line in each direction. The host places an operation code, a 7-bit location and, for programming, a data byte on the command port. It then pulses `cmd_start` for one clock. From then on the controller runs the whole bus transaction by itself. It raises chip select, shifts out a 10-bit instruction and any data byte, and collects a byte for reads. For operations that program the array, it then watches the device's ready/busy indication on the data-in line.

`busy` stays high from the cycle after the start strobe until the command is finished. The finish is marked by a one-cycle `done`. In that same cycle `err_code` carries the outcome, and after a read `rd_data` carries the byte. Both keep their values until the next command. The serial clock rate is set by `HALF_DIV`, the number of system clocks in each serial-clock half period. The longest allowed programming time is set by `POLL_LIMIT`, in system clocks.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: During and right after reset, `ee_cs`, `ee_sclk`, `busy` and `done` are low and `err_code` is 0.
- R2: Every command starts with a 10-bit instruction, sent most significant bit first: a start bit of 1, two opcode bits, then address bits A6 down to A0. `cmd_op` 0 is a read (opcode 10), 1 is a byte write (opcode 01) and 2 is a byte erase (opcode 11), each carrying `cmd_addr`.
- R3: `cmd_op` 3 (erase all), 4 (write all), 5 (enable programming) and 6 or 7 (disable programming) send opcode 00. A6:A5 are 10, 01, 11 and 00 respectively, and the remaining five address bits are sent as 0.
- R4: For a read, the controller samples `ee_di` on the eight rising serial-clock edges that follow the last address bit, most significant bit first. It presents the byte on `rd_data` when `done` pulses.
- R5: For a byte write and for write-all, the eight bits of `cmd_wdata` follow the instruction directly, most significant bit first, within the same chip-select window. This makes 18 serial-clock pulses in total.
- R6: `ee_do` changes only while the serial clock is low, never in the cycle it rises. Each serial-clock high phase lasts exactly `HALF_DIV` system clocks. The serial clock is low whenever chip select is low.
- R7: After a programming instruction, chip select goes low for at least `HALF_DIV` system clocks before it is raised again for the busy poll. After any command it returns low.
- R8: After a programming command (write, erase, erase-all, write-all), the device may show busy by pulling `ee_di` low in the first poll sample. If it does, the command ends with `err_code` 0 once `ee_di` goes high again.
- R9: If `ee_di` is already high at the first poll sample, `HALF_DIV` clocks after chip select is raised again, chip select is dropped and the command ends with `err_code` 1.
- R10: If `ee_di` stays low for `POLL_LIMIT` system clocks of polling, chip select is dropped and the command ends with `err_code` 2.
- R11: A start strobe that arrives while `busy` is high is ignored. No extra bus transaction occurs, and the result of the running command is not changed.
- R12: `done` is a single-cycle pulse, asserted in the cycle `busy` falls. Chip select is never high while `busy` is low. Read, enable and disable commands finish without polling, with `err_code` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 3 | Operation code of the command |
| cmd_addr | input | ADDR_W | Target location |
| cmd_wdata | input | DATA_W | Byte to program (write, write-all) |
| cmd_start | input | 1 | One-cycle command strobe |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte returned by the last read |
| err_code | output | 2 | 0 success, 1 programming never started, 2 busy timeout |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial data toward the EEPROM |
| ee_di | input | 1 | Serial data and ready/busy from the EEPROM |

## Verification
The bench pairs a behavioural EEPROM with per-clock protocol comparisons and goes after the edges of the command set.

- **Address boundaries.** Reads and writes at locations 0, 5 and 127 expose a reversed or off-by-one address shift, which would program the wrong byte.
- **Special commands.** Each opcode-00 command is decoded by the model from the top address bits. A swapped A6:A5 would enable when asked to disable, or fill the array instead of clearing it.
- **Programming while disabled.** The device never goes busy, which must yield code 1 rather than a hang or a false success.
- **Busy timeout.** A device held busy beyond the limit must yield code 2.
- **Mid-command strobe.** A strobe issued in the middle of a read must add no bus transaction and must leave the returned byte alone.

// File: rtl/mwc_pkg.sv
// Shared types for the three-wire EEPROM controller: host operation
// codes, completion codes and controller states.
package mwc_pkg;

    typedef enum logic [2:0] {
        MW_READ       = 3'd0,
        MW_WRITE      = 3'd1,
        MW_ERASE      = 3'd2,
        MW_ERASE_ALL  = 3'd3,
        MW_WRITE_ALL  = 3'd4,
        MW_WR_ENABLE  = 3'd5,
        MW_WR_DISABLE = 3'd6,
        MW_WR_DIS_ALT = 3'd7
    } mw_op_e;

    typedef enum logic [1:0] {
        MW_OK       = 2'd0,
        MW_NO_START = 2'd1,
        MW_TIMEOUT  = 2'd2
    } mw_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_TAIL,
        S_GAP,
        S_POLL1,
        S_POLLW,
        S_FINISH
    } mw_state_e;

endpackage

// File: rtl/mwc_tick.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_DIV system clocks while run is high;
// restarts its count whenever run drops. Assumes HALF_DIV >= 2.
module mwc_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF_DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(HALF_DIV - 1));
endmodule

// File: rtl/mwc_poll_timer.sv
// Busy-poll timeout counter.
// Counts cycles while en is high; expired rises on the POLL_LIMIT-th
// enabled cycle. Clears when en drops. Assumes POLL_LIMIT >= 2.
module mwc_poll_timer #(
    parameter int POLL_LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);
    localparam int TW = $clog2(POLL_LIMIT + 1);

    logic [TW-1:0] cnt;

    // Advance the wait count during polling, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = en && (cnt == TW'(POLL_LIMIT - 1));
endmodule

// File: rtl/mwc_frame.sv
// Command encoder: turns a host operation into the left-aligned serial
// frame (start bit, opcode, address, optional data byte), the total number
// of serial-clock pulses, the number of pulses that carry outgoing bits,
// and flags for programming and read operations. Purely combinational.
module mwc_frame
    import mwc_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 3 + ADDR_W,
    parameter int FRAME_W = INSTR_W + DATA_W,
    parameter int EDGE_W  = $clog2(FRAME_W + 1)
) (
    input  mw_op_e              op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [FRAME_W-1:0]  frame,
    output logic [EDGE_W-1:0]   edges,
    output logic [EDGE_W-1:0]   out_edges,
    output logic                prog,
    output logic                is_read
);
    localparam logic [ADDR_W-3:0] PAD = '0;

    logic [1:0]        opc;
    logic [ADDR_W-1:0] tgt;
    logic              has_data;

    // Select opcode, target field and frame shape from the operation.
    always_comb begin
        opc      = 2'b00;
        tgt      = {2'b00, PAD};
        has_data = 1'b0;
        prog     = 1'b0;
        is_read  = 1'b0;
        unique case (op)
            MW_READ:      begin opc = 2'b10; tgt = addr; is_read = 1'b1; end
            MW_WRITE:     begin opc = 2'b01; tgt = addr; has_data = 1'b1; prog = 1'b1; end
            MW_ERASE:     begin opc = 2'b11; tgt = addr; prog = 1'b1; end
            MW_ERASE_ALL: begin tgt = {2'b10, PAD}; prog = 1'b1; end
            MW_WRITE_ALL: begin tgt = {2'b01, PAD}; has_data = 1'b1; prog = 1'b1; end
            MW_WR_ENABLE: begin tgt = {2'b11, PAD}; end
            default:      begin tgt = {2'b00, PAD}; end
        endcase
        frame     = {1'b1, opc, tgt, (has_data ? wdata : {DATA_W{1'b0}})};
        out_edges = has_data ? EDGE_W'(FRAME_W) : EDGE_W'(INSTR_W);
        edges     = (has_data || is_read) ? EDGE_W'(FRAME_W) : EDGE_W'(INSTR_W);
    end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Three-wire serial EEPROM controller.
// Accepts one command per start strobe while idle, shifts the frame out
// MSB first (data changes on the falling serial clock, input sampled on
// the rising one), and for programming commands polls ready/busy on ee_di
// with a timeout. Assumes HALF_DIV >= 2 and a synchronous ee_di.
module mw_eeprom_ctrl
    import mwc_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 8,
    parameter int HALF_DIV   = 4,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_start,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        err_code,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_do,
    input  logic              ee_di
);
    localparam int INSTR_W = 3 + ADDR_W;
    localparam int FRAME_W = INSTR_W + DATA_W;
    localparam int EDGE_W  = $clog2(FRAME_W + 1);

    mw_state_e           state;
    logic [FRAME_W-1:0]  sh;
    logic [EDGE_W-1:0]   edge_cnt;
    logic [EDGE_W-1:0]   edge_tot;
    logic [EDGE_W-1:0]   out_tot;
    logic                prog_q;
    logic                read_q;
    logic [DATA_W-1:0]   rd_sh;

    logic [FRAME_W-1:0]  f_frame;
    logic [EDGE_W-1:0]   f_edges;
    logic [EDGE_W-1:0]   f_out;
    logic                f_prog;
    logic                f_read;
    logic                tick;
    logic                expired;

    mwc_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .op        (mw_op_e'(cmd_op)),
        .addr      (cmd_addr),
        .wdata     (cmd_wdata),
        .frame     (f_frame),
        .edges     (f_edges),
        .out_edges (f_out),
        .prog      (f_prog),
        .is_read   (f_read)
    );

    mwc_tick #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != S_IDLE),
        .tick  (tick)
    );

    mwc_poll_timer #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state == S_POLLW),
        .expired (expired)
    );

    // Command sequencer: frame shifting, read capture, busy poll, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sh       <= '0;
            edge_cnt <= '0;
            edge_tot <= '0;
            out_tot  <= '0;
            prog_q   <= 1'b0;
            read_q   <= 1'b0;
            rd_sh    <= '0;
            rd_data  <= '0;
            err_code <= MW_OK;
            busy     <= 1'b0;
            done     <= 1'b0;
            ee_cs    <= 1'b0;
            ee_sclk  <= 1'b0;
            ee_do    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    done <= 1'b0;
                    if (cmd_start) begin
                        sh       <= f_frame;
                        edge_tot <= f_edges;
                        out_tot  <= f_out;
                        prog_q   <= f_prog;
                        read_q   <= f_read;
                        edge_cnt <= '0;
                        ee_cs    <= 1'b1;
                        ee_do    <= f_frame[FRAME_W-1];
                        busy     <= 1'b1;
                        err_code <= MW_OK;
                        state    <= S_LOW;
                    end
                end
                S_LOW: begin
                    if (tick) begin
                        ee_sclk  <= 1'b1;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (edge_cnt >= out_tot) begin
                            rd_sh <= {rd_sh[DATA_W-2:0], ee_di};
                        end
                        state <= S_HIGH;
                    end
                end
                S_HIGH: begin
                    if (tick) begin
                        ee_sclk <= 1'b0;
                        if (edge_cnt == edge_tot) begin
                            ee_do <= 1'b0;
                            state <= S_TAIL;
                        end else begin
                            sh    <= sh << 1;
                            ee_do <= sh[FRAME_W-2];
                            state <= S_LOW;
                        end
                    end
                end
                S_TAIL: begin
                    if (tick) begin
                        ee_cs <= 1'b0;
                        state <= prog_q ? S_GAP : S_FINISH;
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        ee_cs <= 1'b1;
                        state <= S_POLL1;
                    end
                end
                S_POLL1: begin
                    if (tick) begin
                        if (ee_di) begin
                            err_code <= MW_NO_START;
                            ee_cs    <= 1'b0;
                            state    <= S_FINISH;
                        end else begin
                            state <= S_POLLW;
                        end
                    end
                end
                S_POLLW: begin
                    if (ee_di) begin
                        ee_cs <= 1'b0;
                        state <= S_FINISH;
                    end else if (expired) begin
                        err_code <= MW_TIMEOUT;
                        ee_cs    <= 1'b0;
                        state    <= S_FINISH;
                    end
                end
                S_FINISH: begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (read_q) begin
                        rd_data <= rd_sh;
                    end
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mwc_checker.sv
// Protocol checker for mw_eeprom_ctrl, attached by bind below.
// Watches only the ports; a counter measures serial-clock high phases.
module mwc_checker #(
    parameter int HALF_DIV = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code,
    input logic       ee_cs,
    input logic       ee_sclk,
    input logic       ee_do
);
    logic [15:0] hi_cnt;

    // Length of the current serial-clock high phase in system clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !ee_sclk) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!ee_cs && !ee_sclk && !busy && !done && err_code == 2'd0));

    assert_do_stable_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sclk) |-> $stable(ee_do));

    assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sclk);

    assert_high_phase_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sclk) |-> (hi_cnt == 16'(HALF_DIV)));

    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |=> !ee_cs);

    assert_err_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code != 2'd3));

    assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start));

    assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cs_needs_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> busy);
endmodule

bind mw_eeprom_ctrl mwc_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .ee_cs     (ee_cs),
    .ee_sclk   (ee_sclk),
    .ee_do     (ee_do)
);

// File: tb/mw_eeprom_ctrl_tb.sv
// Bench: behavioural EEPROM model plus per-clock protocol comparison.
module mw_eeprom_ctrl_tb;
    localparam int HD   = 2;
    localparam int PLIM = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_start = 1'b0;
    logic       busy, done, ee_cs, ee_sclk, ee_do, ee_di;
    logic [7:0] rd_data;
    logic [1:0] err_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mw_eeprom_ctrl #(.HALF_DIV(HD), .POLL_LIMIT(PLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_start(cmd_start), .busy(busy), .done(done),
        .rd_data(rd_data), .err_code(err_code), .ee_cs(ee_cs), .ee_sclk(ee_sclk),
        .ee_do(ee_do), .ee_di(ee_di)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [7:0]  mem [0:127];
    bit          wen = 0;
    int          busy_rem = 0;
    int          busy_len = 300;
    logic [17:0] sh_in = '0;
    int          bitcnt = 0;
    logic [9:0]  last_instr = '0;
    int          last_bits = 0;
    logic [7:0]  last_data = '0;
    int          frames = 0;
    bit          rd_active = 0;
    logic [7:0]  rd_byte = '0;
    int          rd_pos = 0;
    logic        di_bit = 1'b1;
    logic        prev_sclk = 1'b0;
    logic        prev_cs = 1'b0;

    assign ee_di = ee_cs ? ((busy_rem > 0) ? 1'b0 : (rd_active ? di_bit : 1'b1)) : 1'b1;

    always @(negedge clk) begin
        if (busy_rem > 0) busy_rem--;
        if (ee_cs && !prev_cs) begin
            bitcnt = 0; sh_in = '0; rd_active = 0;
        end
        if (ee_cs && ee_sclk && !prev_sclk) begin
            sh_in = {sh_in[16:0], ee_do};
            bitcnt++;
            if (bitcnt == 10 && sh_in[8:7] == 2'b10) begin
                rd_active = 1; rd_byte = mem[sh_in[6:0]]; rd_pos = 8;
            end
        end
        if (ee_cs && !ee_sclk && prev_sclk && rd_active && rd_pos > 0) begin
            di_bit = rd_byte[rd_pos-1];
            rd_pos--;
        end
        if (!ee_cs && prev_cs && bitcnt > 0) begin
            logic [9:0] ins;
            ins = (bitcnt == 18) ? sh_in[17:8] : sh_in[9:0];
            last_instr = ins; last_bits = bitcnt; last_data = sh_in[7:0]; frames++;
            rd_active = 0;
            case (ins[8:7])
                2'b01: if (wen && bitcnt == 18) begin mem[ins[6:0]] = sh_in[7:0]; busy_rem = busy_len; end
                2'b11: if (wen) begin mem[ins[6:0]] = 8'hFF; busy_rem = busy_len; end
                2'b00: case (ins[6:5])
                    2'b11: wen = 1;
                    2'b00: wen = 0;
                    2'b10: if (wen) begin
                        for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
                        busy_rem = busy_len;
                    end
                    default: if (wen && bitcnt == 18) begin
                        for (int i = 0; i < 128; i++) mem[i] = sh_in[7:0];
                        busy_rem = busy_len;
                    end
                endcase
                default: ;
            endcase
        end
        prev_sclk = ee_sclk;
        prev_cs = ee_cs;
    end

    // ---------------- per-clock protocol comparison ----------------
    int hi_run = 0;
    int lo_cs_run = 0;
    int cyc = 0;
    logic mon_sclk = 1'b0;
    logic mon_cs = 1'b0;
    logic mon_do = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(ee_cs || !ee_sclk, "R6 sclk low while cs low", ee_sclk, 0);
            chk(!ee_cs || busy, "R12 cs only while busy", busy, 1);
            chk(!(ee_sclk && mon_sclk) || ee_do == mon_do, "R6 do stable while sclk high", ee_do, mon_do);
            if (!ee_sclk && mon_sclk)
                chk(hi_run == HD, "R6 sclk high phase length", hi_run, HD);
            if (ee_cs && !mon_cs && busy && lo_cs_run > 0)
                chk(lo_cs_run >= HD, "R7 cs low gap before poll", lo_cs_run, HD);
        end
        hi_run = ee_sclk ? hi_run + 1 : 0;
        lo_cs_run = (!ee_cs && busy) ? lo_cs_run + 1 : 0;
        mon_sclk = ee_sclk; mon_cs = ee_cs; mon_do = ee_do;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] rd;
    logic [1:0] er;

    task automatic run_cmd(input logic [2:0] op, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!done) @(negedge clk);
        rd = rd_data; er = err_code;
    endtask

    task automatic read_exp(input logic [6:0] a, input logic [7:0] exp, input string req);
        run_cmd(3'd0, a, 8'h00);
        chk(rd == exp, req, rd, exp);
        chk(last_instr == {3'b110, a}, "R2 read instruction", last_instr, {3'b110, a});
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk(!ee_cs && !ee_sclk && !busy && !done && err_code == 0, "R1 reset state",
            {ee_cs, ee_sclk, busy, done, err_code}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ee_cs && !busy && err_code == 0, "R1 idle after reset", {ee_cs, busy}, 0);

        // enable programming
        run_cmd(3'd5, 7'h55, 8'h00);
        chk(last_instr == 10'h260 && last_bits == 10, "R3 enable frame", last_instr, 10'h260);
        chk(er == 0, "R12 enable no error", er, 0);

        // byte write + read back
        run_cmd(3'd1, 7'h05, 8'hA5);
        chk(last_instr == 10'h285, "R2 write instruction", last_instr, 10'h285);
        chk(last_bits == 18 && last_data == 8'hA5, "R5 write data bits", {last_bits[7:0], last_data}, {8'd18, 8'hA5});
        chk(er == 0, "R8 write poll success", er, 0);
        read_exp(7'h05, 8'hA5, "R4 read byte 0x05");

        run_cmd(3'd1, 7'h7F, 8'h3C);
        chk(er == 0, "R8 write top address", er, 0);
        read_exp(7'h7F, 8'h3C, "R4 read top address");
        read_exp(7'h00, 8'h00, "R4 read address zero");

        // byte erase
        run_cmd(3'd2, 7'h05, 8'h00);
        chk(last_instr == 10'h385 && er == 0, "R2 erase instruction", last_instr, 10'h385);
        read_exp(7'h05, 8'hFF, "R2 erased byte");

        // write all
        run_cmd(3'd4, 7'h12, 8'h5A);
        chk(last_instr == 10'h220 && last_bits == 18 && last_data == 8'h5A, "R3 write-all frame", last_instr, 10'h220);
        read_exp(7'h00, 8'h5A, "R3 write-all low");
        read_exp(7'h7F, 8'h5A, "R3 write-all high");

        // erase all
        run_cmd(3'd3, 7'h7F, 8'h00);
        chk(last_instr == 10'h240 && er == 0, "R3 erase-all frame", last_instr, 10'h240);
        read_exp(7'h33, 8'hFF, "R3 erase-all content");

        // disable, then write: never busy
        run_cmd(3'd6, 7'h7F, 8'h00);
        chk(last_instr == 10'h200 && er == 0, "R3 disable frame", last_instr, 10'h200);
        run_cmd(3'd1, 7'h33, 8'h11);
        chk(er == 1, "R9 never-busy error", er, 1);
        chk(!ee_cs, "R9 cs dropped", ee_cs, 0);
        read_exp(7'h33, 8'hFF, "R9 byte unchanged");

        // alternate disable code
        run_cmd(3'd5, 7'h00, 8'h00);
        run_cmd(3'd7, 7'h6A, 8'h00);
        chk(last_instr == 10'h200, "R3 code 7 disable frame", last_instr, 10'h200);
        run_cmd(3'd5, 7'h00, 8'h00);

        // busy timeout
        busy_len = 3000;
        run_cmd(3'd1, 7'h20, 8'h99);
        chk(er == 2, "R10 busy timeout error", er, 2);
        chk(!ee_cs, "R10 cs dropped", ee_cs, 0);
        while (busy_rem > 0) @(negedge clk);
        busy_len = 300;

        // start ignored while busy
        run_cmd(3'd1, 7'h10, 8'h77);
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            cmd_op = 3'd0; cmd_addr = 7'h10; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            repeat (20) @(negedge clk);
            cmd_op = 3'd1; cmd_addr = 7'h10; cmd_wdata = 8'h00; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            while (!done) @(negedge clk);
            chk(rd_data == 8'h77, "R11 read unaffected", rd_data, 8'h77);
            repeat (10) @(negedge clk);
            chk(frames == f0 + 1 && !busy, "R11 no extra transaction", frames - f0, 1);
        end
        read_exp(7'h10, 8'h77, "R11 memory unchanged");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule